// File: doc/BRIEF.md
# Instruction Prefix and Immediate Predecoder

This block sits at the front of a variable-length instruction decoder and consumes one instruction byte per cycle whenever `byte_vld` is high. Leading bytes are sorted into legacy prefixes, which are packed into an 8-bit prefix vector, and, in long mode, an optional REX byte. The first byte that is neither of these is taken as the opcode.

With the opcode, the caller supplies a small immediate size-type code on `size_type`. The block resolves the effective operand size from the processor mode, REX.W and the operand-size override. It then turns the size type into an immediate byte count, gathers that many bytes little-endian, and raises `done` for one cycle. During that cycle it presents the opcode, the prefix vector, the REX byte, the operand size and the 64-bit immediate. State then clears for the next instruction.

Top module: `insn_prefix_imm_scan`

## Requirements
- R1: Outside the immediate phase, each legacy prefix byte sets one bit of `pfx_out`, and these bits accumulate. The bytes and bits are: 0xF2 sets bit 7, 0xF3 sets bit 6, 0xF0 sets bit 5, 0x67 sets bit 4 and 0x66 sets bit 3.
- R2: `pfx_out[2:0]` holds one segment code. The prefix bytes map to codes as follows: 0x2E gives 1, 0x3E gives 2, 0x26 gives 3, 0x64 gives 4, 0x65 gives 5 and 0x36 gives 6. The value is 0 when no segment prefix is seen, and a later segment prefix replaces an earlier one.
- R3: A byte 0x40–0x4F is a REX byte only when `mode[1]` is 1 (long mode); otherwise it is an opcode. A legacy prefix that follows a REX byte discards it. When no REX byte is kept, `rex_out` is 0.
- R4: In long mode, REX bit 3 set gives operand size 3 (64-bit). Otherwise the 0x66 prefix gives 1 (16-bit), and with neither the size is 2 (32-bit).
- R5: With `mode` = 01 (32-bit default), 0x66 gives size 1 and otherwise the size is 2. With `mode` = 00 (16-bit default), 0x66 gives size 2 and otherwise the size is 1.
- R6: `size_type` is sampled only with the opcode byte, using the codes 0 none, 1 byte, 2 word, 3 dword, 4 qword, 5 oword, 6 vword, 7 zword, 8 enter and 9 pointer. The byte count for sizes 1/2/3 is: none 0, byte 1, word 2, dword 4, qword 8 and oword 16 at every size. vword gives 2/4/4, zword 2/4/8 and enter 3 (both parts as one field), and pointer gives 4/6/0. Codes 10 and above give 0.
- R7: Immediate bytes are assembled little-endian, and only the low 64 bits are kept. During the immediate phase every byte is data, even one whose value matches a prefix.
- R8: When exactly 4 immediate bytes are collected, `imm_out[63:32]` copies bit 31. All other lengths are zero-extended.
- R9: `done` is high for one cycle: either the cycle after the last immediate byte is taken, or the cycle after the opcode when the count is 0. Data outputs are 0 whenever `done` is low. A byte taken during the `done` cycle starts a fresh instruction with no prefixes or REX carried over.
- R10: A synchronous reset on `rst` returns the block to prefix scanning, with `done` low and all fields cleared, including any prefix already gathered.
- R11: A cycle with `byte_vld` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 16-bit default, 01 32-bit default, 1x long mode |
| byte_vld | input | 1 | `byte_in` carries a byte this cycle |
| byte_in | input | 8 | Instruction byte |
| size_type | input | 4 | Immediate size-type code, sampled with the opcode |
| done | output | 1 | One-cycle result strobe |
| op_out | output | 8 | Opcode byte |
| pfx_out | output | 8 | Packed legacy prefix vector |
| rex_out | output | 8 | REX byte, 0 if none |
| osize_out | output | 2 | Operand size code 1/2/3 |
| imm_out | output | 64 | Assembled immediate |

## Verification
The bench drives byte streams made of prefix runs, REX placement and opcode/size-type pairs, together with immediate payloads. Every prefix value is used, including segment prefixes that replace one another, so the bit layout and the segment encoding are told apart. Each operand-size path is exercised in all three modes, including REX followed by 0x66 and 0x48 sent outside long mode. Size types whose length depends on operand size (vword, zword, pointer) are chosen so that a wrong row or column shows up as a mistimed `done`. Payloads with bit 31 set, with prefix-valued bytes, with 16 bytes and with 3 bytes separate sign extension, truncation and data treatment. Further streams cover idle gaps, back-to-back instructions, and a reset in the middle of an instruction.

// File: rtl/insn_prefix_imm_scan.sv
module insn_prefix_imm_scan (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  input  logic [3:0]  size_type,
  output logic        done,
  output logic [7:0]  op_out,
  output logic [7:0]  pfx_out,
  output logic [7:0]  rex_out,
  output logic [1:0]  osize_out,
  output logic [63:0] imm_out
);
  logic        in_imm;
  logic [7:0]  pfx_q, rex_q, op_q;
  logic [1:0]  osz_q;
  logic [63:0] imm_q;
  logic [4:0]  need_q, got_q;

  wire       long_m = mode[1];
  wire [7:0] pfx_b  = done ? 8'h00 : pfx_q;
  wire [7:0] rex_b  = done ? 8'h00 : rex_q;
  wire       is_rex = long_m && (byte_in[7:4] == 4'h4);
  wire       last   = (got_q + 5'd1) == need_q;

  logic       is_leg;
  logic [7:0] pfx_n;
  always_comb begin
    is_leg = 1'b1;
    pfx_n  = pfx_b;
    case (byte_in)
      8'h66:   pfx_n[3] = 1'b1;
      8'h67:   pfx_n[4] = 1'b1;
      8'hF0:   pfx_n[5] = 1'b1;
      8'hF3:   pfx_n[6] = 1'b1;
      8'hF2:   pfx_n[7] = 1'b1;
      8'h2E:   pfx_n[2:0] = 3'd1;
      8'h3E:   pfx_n[2:0] = 3'd2;
      8'h26:   pfx_n[2:0] = 3'd3;
      8'h64:   pfx_n[2:0] = 3'd4;
      8'h65:   pfx_n[2:0] = 3'd5;
      8'h36:   pfx_n[2:0] = 3'd6;
      default: is_leg = 1'b0;
    endcase
  end

  logic [1:0] osz_n;
  always_comb begin
    if (long_m && rex_b[3])            osz_n = 2'd3;
    else if (long_m || mode == 2'b01)  osz_n = pfx_b[3] ? 2'd1 : 2'd2;
    else                               osz_n = pfx_b[3] ? 2'd2 : 2'd1;
  end

  logic [4:0] cnt_n;
  always_comb begin
    case (size_type)
      4'd1:    cnt_n = 5'd1;
      4'd2:    cnt_n = 5'd2;
      4'd3:    cnt_n = 5'd4;
      4'd4:    cnt_n = 5'd8;
      4'd5:    cnt_n = 5'd16;
      4'd6:    cnt_n = (osz_n == 2'd1) ? 5'd2 : 5'd4;
      4'd7:    cnt_n = (osz_n == 2'd1) ? 5'd2 : (osz_n == 2'd2) ? 5'd4 : 5'd8;
      4'd8:    cnt_n = 5'd3;
      4'd9:    cnt_n = (osz_n == 2'd1) ? 5'd4 : (osz_n == 2'd2) ? 5'd6 : 5'd0;
      default: cnt_n = 5'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_imm <= 1'b0;
      done   <= 1'b0;
      pfx_q  <= 8'h00;
      rex_q  <= 8'h00;
      op_q   <= 8'h00;
      osz_q  <= 2'd0;
      imm_q  <= 64'h0;
      need_q <= 5'd0;
      got_q  <= 5'd0;
    end else begin
      done <= 1'b0;
      if (done) begin
        pfx_q <= 8'h00;
        rex_q <= 8'h00;
      end
      if (byte_vld) begin
        if (in_imm) begin
          if (!got_q[4] && !got_q[3]) imm_q[{got_q[2:0], 3'b000} +: 8] <= byte_in;
          got_q <= got_q + 5'd1;
          if (last) begin
            in_imm <= 1'b0;
            done   <= 1'b1;
            if (need_q == 5'd4) imm_q[63:32] <= {32{byte_in[7]}};
          end
        end else if (is_leg) begin
          pfx_q <= pfx_n;
          rex_q <= 8'h00;
        end else if (is_rex) begin
          rex_q <= byte_in;
        end else begin
          op_q   <= byte_in;
          osz_q  <= osz_n;
          need_q <= cnt_n;
          got_q  <= 5'd0;
          imm_q  <= 64'h0;
          pfx_q  <= pfx_b;
          rex_q  <= rex_b;
          if (cnt_n == 5'd0) done   <= 1'b1;
          else               in_imm <= 1'b1;
        end
      end
    end
  end

  assign op_out    = done ? op_q  : 8'h00;
  assign pfx_out   = done ? pfx_q : 8'h00;
  assign rex_out   = done ? rex_q : 8'h00;
  assign osize_out = done ? osz_q : 2'd0;
  assign imm_out   = done ? imm_q : 64'h0;
endmodule

// File: rtl/insn_prefix_imm_scan_chk.sv
module insn_prefix_imm_scan_chk (
  input logic        clk,
  input logic        rst,
  input logic        done,
  input logic [7:0]  pfx_out,
  input logic [7:0]  rex_out,
  input logic [1:0]  osize_out
);
  AST_SEG_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> pfx_out[2:0] != 3'd7); // R2
  AST_OSIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> osize_out != 2'd0); // R4
  AST_REX_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (done && rex_out != 8'h00) |-> rex_out[7:4] == 4'h4); // R3
  AST_WIDE_NEEDS_REXW: assert property (@(posedge clk) disable iff (rst)
    (done && osize_out == 2'd3) |-> rex_out[3]); // R4
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done); // R10
endmodule

bind insn_prefix_imm_scan insn_prefix_imm_scan_chk u_chk (
  .clk(clk), .rst(rst), .done(done),
  .pfx_out(pfx_out), .rex_out(rex_out), .osize_out(osize_out)
);

// File: tb/tb_insn_prefix_imm_scan.sv
module tb_insn_prefix_imm_scan;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'b01;
  logic byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [3:0] size_type = 4'd0;
  logic done;
  logic [7:0] op_out, pfx_out, rex_out;
  logic [1:0] osize_out;
  logic [63:0] imm_out;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_prefix_imm_scan dut (
    .clk(clk), .rst(rst), .mode(mode), .byte_vld(byte_vld), .byte_in(byte_in),
    .size_type(size_type), .done(done), .op_out(op_out), .pfx_out(pfx_out),
    .rex_out(rex_out), .osize_out(osize_out), .imm_out(imm_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int imm_len(input int osz, input int st);
    int tbl [3][10];
    tbl = '{'{0,1,2,4,8,16,2,2,3,4}, '{0,1,2,4,8,16,4,4,3,6}, '{0,1,2,4,8,16,4,8,3,0}};
    if (st > 9) return 0;
    return tbl[osz-1][st];
  endfunction

  task automatic run(input string tag, input logic [7:0] bs[$], input int oi, input int st,
                     input int gap_at, input bit overlap);
    int pfx = 0, rex = 0, osz, n;
    logic [63:0] imm = 64'h0;
    bit lm = mode[1];
    for (int i = 0; i < oi; i++) begin
      bit leg;
      leg = 1'b1;
      case (bs[i])
        8'h66: pfx |= 8;
        8'h67: pfx |= 16;
        8'hF0: pfx |= 32;
        8'hF3: pfx |= 64;
        8'hF2: pfx |= 128;
        8'h2E: pfx = (pfx & ~7) | 1;
        8'h3E: pfx = (pfx & ~7) | 2;
        8'h26: pfx = (pfx & ~7) | 3;
        8'h64: pfx = (pfx & ~7) | 4;
        8'h65: pfx = (pfx & ~7) | 5;
        8'h36: pfx = (pfx & ~7) | 6;
        default: leg = 1'b0;
      endcase
      if (leg) rex = 0; else rex = int'(bs[i]);
    end
    if (lm && rex[3]) osz = 3;
    else if (lm || mode == 2'b01) osz = (pfx & 8) ? 1 : 2;
    else osz = (pfx & 8) ? 2 : 1;
    n = imm_len(osz, st);
    for (int k = 0; k < n && k < 8; k++) imm[k*8 +: 8] = bs[oi+1+k];
    if (n == 4) imm[63:32] = {32{imm[31]}};

    foreach (bs[i]) begin
      if (i == gap_at) begin
        byte_vld = 1'b0; byte_in = 8'h66; size_type = 4'd5;
        @(negedge clk);
        chk(done == 1'b0, {tag, " R11 idle gap"}, done, 0);
      end
      byte_vld = 1'b1; byte_in = bs[i];
      size_type = (i == oi) ? 4'(st) : 4'd5;
      @(negedge clk);
      if (i != bs.size() - 1) chk(done == 1'b0, {tag, " R9 early done"}, done, 0);
    end
    byte_vld = 1'b0; byte_in = 8'h00; size_type = 4'd0;
    chk(done == 1'b1, {tag, " R9 done"}, done, 1);
    chk(op_out == bs[oi], {tag, " opcode"}, op_out, bs[oi]);
    chk(pfx_out == 8'(pfx), {tag, " R1 R2 prefix vector"}, pfx_out, 8'(pfx));
    chk(rex_out == 8'(rex), {tag, " R3 rex"}, rex_out, 8'(rex));
    chk(osize_out == 2'(osz), {tag, " R4 R5 operand size"}, osize_out, 2'(osz));
    chk(imm_out == imm, {tag, " R7 R8 immediate"}, imm_out, imm);
    if (!overlap) begin
      @(negedge clk);
      chk(!done && imm_out == 0 && op_out == 0 && pfx_out == 0 && rex_out == 0,
          {tag, " R9 clear after done"}, {done, op_out, pfx_out}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && imm_out == 0 && pfx_out == 0 && osize_out == 0, "R10 reset state", done, 0);

    mode = 2'b01;
    run("R6 plain", {8'h90}, 0, 0, -1, 0);
    run("R1 R5 all flags", {8'h66, 8'h67, 8'hF0, 8'hF3, 8'hF2, 8'h2E, 8'h6A, 8'h7F}, 6, 1, -1, 0);
    run("R2 seg replace", {8'h2E, 8'h65, 8'h90}, 2, 0, -1, 0);
    run("R2 seg ss", {8'h3E, 8'h26, 8'h64, 8'h36, 8'h90}, 4, 0, -1, 0);
    run("R3 no rex outside long", {8'h48}, 0, 0, -1, 0);
    run("R8 dword negative", {8'hB8, 8'h78, 8'h56, 8'h34, 8'hF2}, 0, 3, -1, 0);
    run("R8 dword positive", {8'hB8, 8'h78, 8'h56, 8'h34, 8'h12}, 0, 7, -1, 0);
    run("R6 R8 enter", {8'hC8, 8'h00, 8'h80, 8'hFF}, 0, 8, -1, 0);
    run("R7 oword", {8'h0F, 8'h66, 8'hF0, 8'h2E, 8'h48, 8'h05, 8'h06, 8'h07, 8'h88,
                     8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h99}, 0, 5, -1, 0);
    run("R6 pointer 32", {8'h9A, 1, 2, 3, 4, 5, 6}, 0, 9, -1, 0);
    run("R6 invalid type", {8'hCC}, 0, 12, -1, 0);
    run("R11 gap", {8'h66, 8'h68, 8'h34, 8'h92}, 1, 7, 2, 0);

    mode = 2'b00;
    run("R5 16 default", {8'h9A, 8'h10, 8'h20, 8'h30, 8'h40}, 0, 9, -1, 0);
    run("R5 16 override", {8'h66, 8'h9A, 1, 2, 3, 4, 5, 6}, 1, 9, -1, 0);

    mode = 2'b10;
    run("R4 rexw zword", {8'h48, 8'hB8, 1, 2, 3, 4, 5, 6, 7, 8'h89}, 1, 7, -1, 0);
    run("R4 long override", {8'h66, 8'hB8, 8'h34, 8'h12}, 1, 7, -1, 0);
    run("R4 long plain vword", {8'h68, 8'h00, 8'h00, 8'h00, 8'h80}, 0, 6, -1, 0);
    run("R3 rex then legacy", {8'h48, 8'h66, 8'hB8, 8'h34, 8'h12}, 2, 7, -1, 0);
    run("R3 R6 pointer 64", {8'h41, 8'h49, 8'h9A}, 2, 9, -1, 0);
    run("R9 overlap a", {8'h48, 8'h05, 8'h01, 8'h02, 8'h03, 8'h84}, 1, 3, -1, 1);
    run("R9 overlap b", {8'hF3, 8'hA4}, 1, 0, -1, 1);
    run("R9 overlap c", {8'h90}, 0, 0, -1, 0);

    mode = 2'b11;
    run("R4 mode3 long", {8'h48, 8'hB8, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 8'h01, 8'h02, 8'h03, 8'h04}, 1, 7, -1, 0);

    mode = 2'b01;
    byte_vld = 1'b1; byte_in = 8'h66; size_type = 4'd0;
    @(negedge clk);
    byte_vld = 1'b1; byte_in = 8'h2E;
    rst = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0; rst = 1'b0;
    run("R10 mid reset", {8'h6A, 8'h05}, 0, 1, -1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule